// File: doc/BRIEF.md
# Low-Frequency Oscillator Failure Monitor with Failover

This block watches an external low-frequency oscillator (nominally 32.768 kHz) and uses a free-running internal low-frequency clock as its time base. All of its state lives in that reference domain. The external clock is brought in through a two-flop synchronizer, and its rising edges are detected there. A saturating counter measures the time since the last edge. If no edge arrives for 8 reference cycles, the external oscillator is reported as stopped.

Software sees two bits in a 2-bit status register. Bit 0 is a sticky failure flag. Bit 1 is the live "external oscillator inactive" indication. Monitoring is armed only while the monitor enable is high and the external source is the configured clock source. An armed monitor that sees the oscillator stop sets the flag. The clock-select output then moves to the internal source in the same cycle, without waiting for software. Software writes 1 to bit 0 to clear the flag, and the clear is accepted only while bit 1 reads 0. After an accepted clear, the select output stays on the internal source for 2 more reference cycles and then returns to the external source. The select output is a function of registered state and the static source configuration only.

Top module: `osc_guard`

## Requirements
- R1: During and after a synchronous active-low reset, the failure flag (rd_data bit 0) is 0, the live status (rd_data bit 1) is 0, and clk_sel equals ext_mode (1 = external source, 0 = internal source).
- R2: rd_data bit 1 reads 1 once 8 or more reference cycles have passed without a synchronized rising edge of ext_clk. It reads 0 again after the cycle in which an edge is seen. An oscillator whose rising edges are 8 reference cycles apart never reads 1.
- R3: The failure flag is set on the clock edge after the live status reads 1 while both mon_en and ext_mode are 1. With either of them at 0, a stopped oscillator does not set the flag.
- R4: Whenever the failure flag is 1, clk_sel is 0 (internal source), including the first cycle in which the flag reads 1.
- R5: A write (wr_en = 1) with wr_data bit 0 = 1 while the live status reads 0 clears the failure flag at that clock edge.
- R6: A write of 1 to bit 0 while the live status reads 1 is ignored, and the flag stays 1.
- R7: A write with wr_data bit 0 = 0 has no effect on the failure flag.
- R8: After an accepted clear, clk_sel stays 0 for the first 2 cycles in which the flag reads 0, and then returns to 1 if ext_mode is 1.
- R9: The failure flag is sticky. It stays 1 after the oscillator resumes and after monitoring is disarmed, until an accepted clear or a reset.
- R10: While ext_mode is 0, clk_sel is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Internal low-frequency reference clock; all state is clocked by it |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External low-frequency oscillator, asynchronous to ref_clk |
| mon_en | input | 1 | Enables the monitoring function |
| ext_mode | input | 1 | 1 when the external oscillator is the configured clock source |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2 | Write data; bit 0 = 1 requests a clear of the failure flag, bit 1 is read-only |
| rd_data | output | 2 | Status: bit 0 failure flag, bit 1 external oscillator inactive |
| clk_sel | output | 1 | Clock source select: 1 external, 0 internal |

## Verification
The external clock is driven with toggle half-periods of 2, 4 and 5 reference cycles, and it is also held at a fixed level. Half-period 4 puts edges exactly 8 cycles apart and must never report a stop. Half-period 5 must report a stop in the gap between edges, so these two patterns pin down the timeout boundary on both sides. Clear writes are placed while the oscillator is stopped, while it is running, and with the clear bit at 0, which separates the accepted clear from the ignored ones. Failures are raised with monitoring armed and with it disarmed, and the select output is followed cycle by cycle through the post-clear hold.

// File: rtl/osc_guard_pkg.sv
// Shared constants and types for the oscillator failure monitor.
// Assumes a 2-bit status/write register with fixed bit positions.
package osc_guard_pkg;
    localparam int REG_W    = 2;
    localparam int FAIL_BIT = 0;   // sticky failure flag, write 1 to clear
    localparam int LIVE_BIT = 1;   // external oscillator inactive, read-only

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;
endpackage

// File: rtl/osc_edge_sync.sv
// Brings an asynchronous slow clock into the reference domain through a
// STAGES-deep flop chain and emits a one-cycle pulse per rising edge.
// Assumes the input is slower than half the reference frequency.
module osc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // capture the raw asynchronous level
                always_ff @(posedge ref_clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                // pass the level one stage further down the chain
                always_ff @(posedge ref_clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // remember the previous synchronized level for edge detection
    always_ff @(posedge ref_clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    // rising edge of the synchronized level
    always_comb rise_o = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/osc_stall_timer.sv
// Counts reference cycles since the last detected edge and saturates at
// TIMEOUT; the stalled output is high while the count sits at TIMEOUT.
// Assumes TIMEOUT >= 1.
module osc_stall_timer #(
    parameter int TIMEOUT = 8
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic stalled_o
);
    localparam int             CW    = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0]  LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] idle_q;

    // restart on an edge, otherwise count up to the limit and hold there
    always_ff @(posedge ref_clk) begin
        if (!rst_n)               idle_q <= '0;
        else if (rise_i)          idle_q <= '0;
        else if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
    end

    // oscillator considered stopped once the limit is reached
    always_comb stalled_o = (idle_q == LIMIT);
endmodule

// File: rtl/osc_fail_ctrl.sv
// Holds the sticky failure flag and the post-clear hold-off counter.
// A clear is accepted only while the flag is set and the oscillator is
// not stalled; setting and accepted clearing are therefore exclusive.
module osc_fail_ctrl #(
    parameter int HOLD = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic stalled_i,
    input  logic clr_req_i,
    output logic fail_o,
    output logic hold_busy_o
);
    localparam int HW = $clog2(HOLD + 1);

    logic          fail_q;
    logic [HW-1:0] hold_q;
    logic          set_now;
    logic          clr_ok;

    // decide this cycle's set and clear events
    always_comb begin
        set_now = arm_i & stalled_i;
        clr_ok  = clr_req_i & ~stalled_i & fail_q;
    end

    // sticky flag: set on an armed stall, cleared by an accepted write
    always_ff @(posedge ref_clk) begin
        if (!rst_n)       fail_q <= 1'b0;
        else if (set_now) fail_q <= 1'b1;
        else if (clr_ok)  fail_q <= 1'b0;
    end

    // hold-off: keep the internal source a few cycles after a clear
    always_ff @(posedge ref_clk) begin
        if (!rst_n)            hold_q <= '0;
        else if (clr_ok)       hold_q <= HW'(HOLD);
        else if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end

    // expose flag and hold-off state
    always_comb begin
        fail_o      = fail_q;
        hold_busy_o = (hold_q != '0);
    end
endmodule

// File: rtl/osc_guard.sv
// Top of the oscillator failure monitor. Everything runs on the internal
// reference clock. The select output depends only on registered state and
// the static source configuration, so it carries no data-path glitches.
module osc_guard #(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT     = 8,
    parameter int HOLD        = 2
) (
    input  logic                            ref_clk,
    input  logic                            rst_n,
    input  logic                            ext_clk,
    input  logic                            mon_en,
    input  logic                            ext_mode,
    input  logic                            wr_en,
    input  logic [osc_guard_pkg::REG_W-1:0] wr_data,
    output logic [osc_guard_pkg::REG_W-1:0] rd_data,
    output logic                            clk_sel
);
    import osc_guard_pkg::*;

    logic rise;
    logic stalled;
    logic fail;
    logic hold_busy;
    logic arm;
    logic clr_req;
    logic wr_ro_unused;
    src_e src;

    osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .async_in(ext_clk),
        .rise_o  (rise)
    );

    osc_stall_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .stalled_o(stalled)
    );

    osc_fail_ctrl #(.HOLD(HOLD)) u_ctrl (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .arm_i      (arm),
        .stalled_i  (stalled),
        .clr_req_i  (clr_req),
        .fail_o     (fail),
        .hold_busy_o(hold_busy)
    );

    // arming condition and write decode
    always_comb begin
        arm          = mon_en & ext_mode;
        clr_req      = wr_en & wr_data[FAIL_BIT];
        wr_ro_unused = wr_data[LIVE_BIT];
    end

    // source choice: external only when configured, healthy and settled
    always_comb begin
        src = (ext_mode && !fail && !hold_busy) ? SRC_EXT : SRC_INT;
        clk_sel = src;
    end

    // status register read view
    always_comb begin
        rd_data           = '0;
        rd_data[FAIL_BIT] = fail;
        rd_data[LIVE_BIT] = stalled;
    end
endmodule

// File: rtl/osc_guard_chk.sv
// Property checker for osc_guard, observing its ports only.
module osc_guard_chk (
    input logic                            ref_clk,
    input logic                            rst_n,
    input logic                            mon_en,
    input logic                            ext_mode,
    input logic                            wr_en,
    input logic                            wr_clr,
    input logic [osc_guard_pkg::REG_W-1:0] rd_data,
    input logic                            clk_sel
);
    import osc_guard_pkg::*;

    // R4
    sel_int_on_fail_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        rd_data[FAIL_BIT] |-> !clk_sel);

    // R10
    sel_int_mode_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !ext_mode |-> !clk_sel);

    // R3
    fail_sets_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mon_en && ext_mode && rd_data[LIVE_BIT]) |=> rd_data[FAIL_BIT]);

    // R6
    no_clear_stopped_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (rd_data[FAIL_BIT] && rd_data[LIVE_BIT]) |=> rd_data[FAIL_BIT]);

    // R7
    sticky_no_w1_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (rd_data[FAIL_BIT] && !(wr_en && wr_clr)) |=> rd_data[FAIL_BIT]);

    // R8
    hold_after_clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(rd_data[FAIL_BIT]) |-> !clk_sel);

    // R8
    hold_second_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(rd_data[FAIL_BIT]) |=> !clk_sel);
endmodule

bind osc_guard osc_guard_chk u_chk (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .mon_en  (mon_en),
    .ext_mode(ext_mode),
    .wr_en   (wr_en),
    .wr_clr  (wr_data[osc_guard_pkg::FAIL_BIT]),
    .rd_data (rd_data),
    .clk_sel (clk_sel)
);

// File: tb/tb_osc_guard.sv
module tb_osc_guard;
    localparam int CLK_PERIOD = 10;
    localparam int TO         = 8;
    localparam int HOLDC      = 2;

    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       mon_en = 1'b1;
    logic       ext_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic [1:0] rd_data;
    logic       clk_sel;

    int  vectors = 0;
    int  miscompares = 0;
    bit  ext_run = 1'b0;
    int  ext_half = 2;
    int  ext_cnt = 0;
    bit  model_ok = 1'b0;

    // behavioural reference state
    bit  hist[$];
    int  idle = 0;
    bit  mfail = 1'b0;
    int  mhold = 0;

    osc_guard dut (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .mon_en  (mon_en),
        .ext_mode(ext_mode),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .clk_sel (clk_sel)
    );

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    // external oscillator generator, toggling on ref negedges
    always @(negedge ref_clk) begin
        if (ext_run) begin
            ext_cnt = ext_cnt + 1;
            if (ext_cnt >= ext_half) begin
                ext_cnt = 0;
                ext_clk = ~ext_clk;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: history of sampled ext levels, idle-cycle count
    always @(posedge ref_clk) begin
        if (!rst_n) begin
            hist = '{0, 0, 0};
            idle = 0;
            mfail = 0;
            mhold = 0;
            model_ok = 1'b1;
        end else begin
            bit edge_seen;
            bit stopped;
            bit accept;
            edge_seen = hist[1] && !hist[2];
            stopped = (idle >= TO);
            accept = wr_en && wr_data[0] && !stopped && mfail;
            if (mon_en && ext_mode && stopped) mfail = 1;
            else if (accept) mfail = 0;
            if (accept) mhold = HOLDC;
            else if (mhold > 0) mhold = mhold - 1;
            if (edge_seen) idle = 0;
            else if (idle < TO) idle = idle + 1;
            hist.push_front(ext_clk);
            void'(hist.pop_back());
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge ref_clk) begin
        if (model_ok) begin
            check("R2 live status", int'(rd_data[1]), (idle >= TO) ? 1 : 0);
            check("R3 failure flag", int'(rd_data[0]), int'(mfail));
            check("R4 clk_sel", int'(clk_sel),
                  (ext_mode && !mfail && mhold == 0) ? 1 : 0);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wr(bit v);
        wr_en = 1'b1;
        wr_data = {1'b0, v};
        @(negedge ref_clk);
        wr_en = 1'b0;
        wr_data = 2'b00;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge ref_clk);
        miscompares++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        cyc(3);
        check("R1 flag in reset", int'(rd_data[0]), 0);
        check("R1 sel in reset", int'(clk_sel), 1);
        rst_n = 1'b1;
        cyc(1);
        check("R1 flag after reset", int'(rd_data[0]), 0);
        check("R1 status after reset", int'(rd_data[1]), 0);
        check("R1 sel after reset", int'(clk_sel), 1);

        ext_half = 2; ext_run = 1'b1;
        cyc(40);
        check("R2 running status", int'(rd_data[1]), 0);
        check("R3 no failure while running", int'(rd_data[0]), 0);

        ext_run = 1'b0;
        cyc(20);
        check("R2 stopped status", int'(rd_data[1]), 1);
        check("R3 failure set", int'(rd_data[0]), 1);
        check("R4 sel internal", int'(clk_sel), 0);

        wr(1'b1);
        check("R6 clear while stopped ignored", int'(rd_data[0]), 1);

        ext_run = 1'b1;
        cyc(20);
        check("R9 flag sticky after resume", int'(rd_data[0]), 1);
        check("R2 status back to 0", int'(rd_data[1]), 0);
        wr(1'b0);
        check("R7 write 0 no effect", int'(rd_data[0]), 1);
        wr(1'b1);
        check("R5 clear accepted", int'(rd_data[0]), 0);
        check("R8 hold cycle 1", int'(clk_sel), 0);
        cyc(1);
        check("R8 hold cycle 2", int'(clk_sel), 0);
        cyc(1);
        check("R8 back to external", int'(clk_sel), 1);

        mon_en = 1'b0;
        ext_run = 1'b0;
        cyc(20);
        check("R3 disarmed no failure", int'(rd_data[0]), 0);
        check("R2 disarmed status", int'(rd_data[1]), 1);
        mon_en = 1'b1;
        cyc(1);
        check("R3 armed sets", int'(rd_data[0]), 1);
        check("R4 sel follows flag", int'(clk_sel), 0);
        mon_en = 1'b0;
        cyc(3);
        check("R9 sticky when disarmed", int'(rd_data[0]), 1);
        ext_mode = 1'b0;
        cyc(1);
        check("R10 internal mode", int'(clk_sel), 0);

        ext_run = 1'b1;
        cyc(20);
        wr(1'b1);
        check("R5 clear in internal mode", int'(rd_data[0]), 0);
        cyc(4);
        check("R10 sel stays internal", int'(clk_sel), 0);
        ext_mode = 1'b1;
        mon_en = 1'b1;

        ext_half = 4;
        cyc(80);
        check("R2 8-cycle edge spacing not stopped", int'(rd_data[0]), 0);

        ext_half = 5;
        cyc(40);
        check("R2 10-cycle edge spacing stops", int'(rd_data[0]), 1);

        ext_mode = 1'b0;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        check("R1 flag after second reset", int'(rd_data[0]), 0);
        check("R1 sel follows internal mode", int'(clk_sel), 0);
        ext_mode = 1'b1;
        cyc(1);
        check("R1 sel follows external mode", int'(clk_sel), 1);

        cyc(5);
        finish_run();
    end
endmodule